// File: doc/BRIEF.md
# Programmable event-to-task router

The router links single-cycle event pulses from peripherals to task trigger pulses, with no processor in the path. It has 32 channels. Each channel holds three endpoint addresses: one event endpoint and two task endpoints (a primary and a fork). When the event named by a channel's event endpoint fires and the channel is enabled, the tasks named by both task endpoints pulse together in a single clock cycle.

Events arrive as a vector in which bit i stands for the event register at address `EVT_BASE + 4*i`. Tasks leave as a vector in which bit j stands for the task register at address `TASK_BASE + 4*j`. Every event passes through one register on the block clock before it can reach a task. Channels 0 to 19 are fully programmable. Channels 20 to 31 have event and primary task endpoints fixed at build time, but their fork endpoint can still be written. A per-channel enable mask comes from outside the block.

Endpoints are written and read through a plain strobe port. Reads return data one cycle after the strobe.

Top module: `evtask_router`

## Requirements
- R1: After a synchronous active-low reset, every writable endpoint reads 0 and no task output is high in the first cycle after reset.
- R2: An event bit that is high in clock cycle k makes the primary and fork tasks of each enabled matching channel high in cycle k+1 only. In cycle k itself nothing is high. A one-cycle event gives a one-cycle task pulse.
- R3: For programmable channels n = 0..19, the event endpoint is at offset 0x510+8n and the primary task endpoint is at 0x514+8n. For all channels n = 0..31, the fork endpoint is at 0x910+4n. A write stores the full 32-bit value. A read strobe returns the stored value on `rd_data` in the next cycle, and `rd_data` holds its value while no read strobe is given.
- R4: For channels 20..31, the slots 0x510+8n and 0x514+8n read back the fixed event and task addresses. Writes to these slots are ignored. The default fixed events for channels 20..31 are indices 0,0,1,2,3,4,4,5,6,6,6,6, and the default fixed tasks are indices 0,1,2,3,4,5,6,7,0,1,6,7.
- R5: The fork endpoint of a fixed channel is writable, and it fires together with that channel's fixed primary task.
- R6: The event address map is `EVT_BASE + 4*i` (default 0x100) for i = 0..7. The task address map is `TASK_BASE + 4*j` (default 0x040) for j = 0..7. An endpoint value outside its own group's map never fires. This includes zero, a misaligned value, and an address taken from the other group.
- R7: A channel whose `ch_en` bit is low in the cycle its registered event is present produces no task pulse.
- R8: One event may feed several channels, and several channels may drive one task. Each task output is the OR over all firing channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | NUM_EVT | Event pulses, bit i = event address EVT_BASE+4i |
| ch_en | input | NUM_CH | Per-channel enable mask |
| wr_en | input | 1 | Endpoint write strobe |
| wr_addr | input | 12 | Endpoint write offset |
| wr_data | input | 32 | Endpoint write value |
| rd_en | input | 1 | Endpoint read strobe |
| rd_addr | input | 12 | Endpoint read offset |
| rd_data | output | 32 | Read value, valid the cycle after rd_en |
| task_o | output | NUM_TASK | Task pulses, bit j = task address TASK_BASE+4j |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any traffic. They also assume that `evt_in` is clean on the clock, so that the single synchronising register fully defines when a task may pulse. The bench drives every input on the falling edge and only raises events for one cycle at a time. The enable mask is held steady across each pulse, so each check sees exactly one registered event and one enable value.

// File: rtl/evtask_pkg.sv
// Shared constants and helpers for the event-to-task router.
// Assumes endpoint offsets fit in 12 bits and maps hold at most 64 entries.
package evtask_pkg;

    localparam int unsigned EP_W     = 32;
    localparam int unsigned OFS_W    = 12;
    localparam logic [11:0] EEP_OFS  = 12'h510;
    localparam logic [11:0] TEP_OFS  = 12'h514;
    localparam logic [11:0] FORK_OFS = 12'h910;

    // Turn an endpoint address into a one-hot index within a map of n
    // word-spaced registers starting at base; zero when nothing matches.
    function automatic logic [63:0] hot_of(input logic [31:0] a,
                                           input logic [31:0] base,
                                           input int          n);
        logic [63:0] h;
        h = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < n && a == base + 32'(4 * i)) h[i] = 1'b1;
        end
        return h;
    endfunction

endpackage

// File: rtl/evtask_evt_sync.sv
// Event synchronising stage: re-registers every event bit on the block
// clock so that a clock-synchronous event reaches the router one cycle later.
// Assumes evt_in is already free of metastability for this clock.
module evtask_evt_sync #(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic [NUM_EVT-1:0] evt_q
);

    // Capture the event vector once per clock, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_in;
    end

endmodule

// File: rtl/evtask_ep_regs.sv
// Endpoint storage: holds the event, primary task and fork task endpoint
// for every channel, keeps a one-hot decode of each beside the raw value,
// and serves a registered read port. Channels at or above NUM_PROG have
// constant event and primary endpoints taken from FIX_EVT / FIX_TASK
// (8-bit index per channel, lowest fixed channel in the lowest byte).
// Assumes NUM_EVT and NUM_TASK are at most 64.
module evtask_ep_regs
    import evtask_pkg::*;
#(
    parameter int          NUM_CH    = 32,
    parameter int          NUM_PROG  = 20,
    parameter int          NUM_EVT   = 8,
    parameter int          NUM_TASK  = 8,
    parameter logic [31:0] EVT_BASE  = 32'h0000_0100,
    parameter logic [31:0] TASK_BASE = 32'h0000_0040,
    parameter logic [(NUM_CH-NUM_PROG)*8-1:0] FIX_EVT  = 96'h06060606_05040403_02010000,
    parameter logic [(NUM_CH-NUM_PROG)*8-1:0] FIX_TASK = 96'h07060100_07060504_03020100
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [OFS_W-1:0]                   wr_addr,
    input  logic [EP_W-1:0]                    wr_data,
    input  logic                               rd_en,
    input  logic [OFS_W-1:0]                   rd_addr,
    output logic [EP_W-1:0]                    rd_data,
    output logic [NUM_CH-1:0][NUM_EVT-1:0]     eep_hot,
    output logic [NUM_CH-1:0][NUM_TASK-1:0]    tep_hot,
    output logic [NUM_CH-1:0][NUM_TASK-1:0]    fork_hot
);

    logic [EP_W-1:0]     eep_val  [NUM_CH];
    logic [EP_W-1:0]     tep_val  [NUM_CH];
    logic [EP_W-1:0]     fork_val [NUM_CH];
    logic [NUM_EVT-1:0]  wr_evt_hot;
    logic [NUM_TASK-1:0] wr_task_hot;
    logic [EP_W-1:0]     rd_mux;

    // Decode the write value once for every endpoint register that takes it.
    assign wr_evt_hot  = NUM_EVT'(hot_of(wr_data, EVT_BASE, NUM_EVT));
    assign wr_task_hot = NUM_TASK'(hot_of(wr_data, TASK_BASE, NUM_TASK));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [OFS_W-1:0] A_EEP  = EEP_OFS + OFS_W'(8 * c);
        localparam logic [OFS_W-1:0] A_TEP  = TEP_OFS + OFS_W'(8 * c);
        localparam logic [OFS_W-1:0] A_FORK = FORK_OFS + OFS_W'(4 * c);

        logic [EP_W-1:0]     r_fork;
        logic [NUM_TASK-1:0] r_fork_hot;

        // Fork endpoint: writable on every channel, raw value and decode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_fork     <= '0;
                r_fork_hot <= '0;
            end else if (wr_en && wr_addr == A_FORK) begin
                r_fork     <= wr_data;
                r_fork_hot <= wr_task_hot;
            end
        end
        assign fork_val[c] = r_fork;
        assign fork_hot[c] = r_fork_hot;

        if (c < NUM_PROG) begin : g_prog
            logic [EP_W-1:0]     r_eep;
            logic [EP_W-1:0]     r_tep;
            logic [NUM_EVT-1:0]  r_eep_hot;
            logic [NUM_TASK-1:0] r_tep_hot;

            // Programmable event endpoint with its one-hot decode.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    r_eep     <= '0;
                    r_eep_hot <= '0;
                end else if (wr_en && wr_addr == A_EEP) begin
                    r_eep     <= wr_data;
                    r_eep_hot <= wr_evt_hot;
                end
            end

            // Programmable primary task endpoint with its one-hot decode.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    r_tep     <= '0;
                    r_tep_hot <= '0;
                end else if (wr_en && wr_addr == A_TEP) begin
                    r_tep     <= wr_data;
                    r_tep_hot <= wr_task_hot;
                end
            end

            assign eep_val[c] = r_eep;
            assign tep_val[c] = r_tep;
            assign eep_hot[c] = r_eep_hot;
            assign tep_hot[c] = r_tep_hot;
        end else begin : g_fixed
            localparam logic [7:0] EI = FIX_EVT[(c-NUM_PROG)*8 +: 8];
            localparam logic [7:0] TI = FIX_TASK[(c-NUM_PROG)*8 +: 8];

            // Constant endpoints; writes to their slots reach nothing.
            assign eep_val[c] = EVT_BASE + 32'(EI) * 32'd4;
            assign tep_val[c] = TASK_BASE + 32'(TI) * 32'd4;
            assign eep_hot[c] = NUM_EVT'(1) << EI;
            assign tep_hot[c] = NUM_TASK'(1) << TI;
        end

        // R6: every stored decode names at most one event or task.
        p_hot_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(eep_hot[c]) && $onehot0(tep_hot[c]) && $onehot0(fork_hot[c]));
    end

    // Select the endpoint addressed by the read offset.
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == EEP_OFS + OFS_W'(8 * c))  rd_mux = eep_val[c];
            if (rd_addr == TEP_OFS + OFS_W'(8 * c))  rd_mux = tep_val[c];
            if (rd_addr == FORK_OFS + OFS_W'(4 * c)) rd_mux = fork_val[c];
        end
    end

    // Register read data on the read strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    // R3: read data changes only after a read strobe.
    p_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/evtask_xbar.sv
// Channel crossbar: a channel fires when it is enabled and its registered
// event is present; a firing channel drives its primary and fork task
// bits, and all channels are ORed onto the task vector.
// Assumes decodes are one-hot or zero; a zero decode connects nothing.
module evtask_xbar #(
    parameter int NUM_CH   = 32,
    parameter int NUM_EVT  = 8,
    parameter int NUM_TASK = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_EVT-1:0]              evt_q,
    input  logic [NUM_CH-1:0]               ch_en,
    input  logic [NUM_CH-1:0][NUM_EVT-1:0]  eep_hot,
    input  logic [NUM_CH-1:0][NUM_TASK-1:0] tep_hot,
    input  logic [NUM_CH-1:0][NUM_TASK-1:0] fork_hot,
    output logic [NUM_TASK-1:0]             task_o
);

    // Merge the task bits of every enabled channel whose event is present.
    always_comb begin
        task_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_en[c] && (|(evt_q & eep_hot[c])))
                task_o |= tep_hot[c] | fork_hot[c];
        end
    end

    // R7: with every channel disabled, no task pulses.
    p_disabled_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == '0) |-> (task_o == '0));

    // R2: no registered event, no task pulse.
    p_idle_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q == '0) |-> (task_o == '0));

endmodule

// File: rtl/evtask_router.sv
// Top of the event-to-task router: event synchroniser, endpoint storage
// and channel crossbar. Task outputs follow the registered event, so a
// clock-synchronous event shows at the task outputs exactly one cycle later.
// Assumes rst_n is held low for at least one rising edge.
module evtask_router
    import evtask_pkg::*;
#(
    parameter int          NUM_CH    = 32,
    parameter int          NUM_PROG  = 20,
    parameter int          NUM_EVT   = 8,
    parameter int          NUM_TASK  = 8,
    parameter logic [31:0] EVT_BASE  = 32'h0000_0100,
    parameter logic [31:0] TASK_BASE = 32'h0000_0040,
    parameter logic [(NUM_CH-NUM_PROG)*8-1:0] FIX_EVT  = 96'h06060606_05040403_02010000,
    parameter logic [(NUM_CH-NUM_PROG)*8-1:0] FIX_TASK = 96'h07060100_07060504_03020100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EVT-1:0]  evt_in,
    input  logic [NUM_CH-1:0]   ch_en,
    input  logic                wr_en,
    input  logic [11:0]         wr_addr,
    input  logic [31:0]         wr_data,
    input  logic                rd_en,
    input  logic [11:0]         rd_addr,
    output logic [31:0]         rd_data,
    output logic [NUM_TASK-1:0] task_o
);

    logic [NUM_EVT-1:0]              evt_q;
    logic [NUM_CH-1:0][NUM_EVT-1:0]  eep_hot;
    logic [NUM_CH-1:0][NUM_TASK-1:0] tep_hot;
    logic [NUM_CH-1:0][NUM_TASK-1:0] fork_hot;

    evtask_evt_sync #(
        .NUM_EVT (NUM_EVT)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_in (evt_in),
        .evt_q  (evt_q)
    );

    evtask_ep_regs #(
        .NUM_CH    (NUM_CH),
        .NUM_PROG  (NUM_PROG),
        .NUM_EVT   (NUM_EVT),
        .NUM_TASK  (NUM_TASK),
        .EVT_BASE  (EVT_BASE),
        .TASK_BASE (TASK_BASE),
        .FIX_EVT   (FIX_EVT),
        .FIX_TASK  (FIX_TASK)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .eep_hot  (eep_hot),
        .tep_hot  (tep_hot),
        .fork_hot (fork_hot)
    );

    evtask_xbar #(
        .NUM_CH   (NUM_CH),
        .NUM_EVT  (NUM_EVT),
        .NUM_TASK (NUM_TASK)
    ) u_xbar (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_q    (evt_q),
        .ch_en    (ch_en),
        .eep_hot  (eep_hot),
        .tep_hot  (tep_hot),
        .fork_hot (fork_hot),
        .task_o   (task_o)
    );

    // R2: a task pulse is always caused by an event one cycle earlier.
    p_task_needs_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (task_o != '0) |-> ($past(evt_in) != '0));

    // R1: the first cycle after reset is quiet.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (task_o == '0));

endmodule

// File: tb/evtask_router_bench.sv
// Directed bench for the event-to-task router, one task per scenario.
module evtask_router_bench;

    localparam logic [31:0] EB = 32'h100;
    localparam logic [31:0] TB = 32'h040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_in = '0;
    logic [31:0] ch_en = '0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  task_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int fx_e [12] = '{0, 0, 1, 2, 3, 4, 4, 5, 6, 6, 6, 6};
    int fx_t [12] = '{0, 1, 2, 3, 4, 5, 6, 7, 0, 1, 6, 7};

    logic [31:0] m_eep  [32];
    logic [31:0] m_tep  [32];
    logic [31:0] m_fork [32];

    always #2.5 clk = ~clk;

    evtask_router u_evtask_router (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .ch_en(ch_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .task_o(task_o)
    );

    function automatic logic [31:0] ea(int i); return EB + 32'(4 * i); endfunction
    function automatic logic [31:0] ta(int i); return TB + 32'(4 * i); endfunction

    // Expected task vector from the requirement model.
    function automatic logic [7:0] exp_task(logic [7:0] ev, logic [31:0] en);
        logic [7:0] r = '0;
        for (int c = 0; c < 32; c++) begin
            if (!en[c]) continue;
            for (int e = 0; e < 8; e++) begin
                if (ev[e] && m_eep[c] == ea(e)) begin
                    for (int t = 0; t < 8; t++) begin
                        if (m_tep[c] == ta(t))  r[t] = 1'b1;
                        if (m_fork[c] == ta(t)) r[t] = 1'b1;
                    end
                end
            end
        end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    // Pulse events for one cycle and check before, at and after latency.
    task automatic fire(string req, logic [7:0] ev, logic [31:0] en);
        @(negedge clk); evt_in = ev; ch_en = en;
        #1 chk({req, " same-cycle"}, 32'(task_o), 32'h0);
        @(negedge clk); evt_in = '0;
        chk({req, " next-cycle"}, 32'(task_o), 32'(exp_task(ev, en)));
        @(negedge clk);
        chk({req, " pulse-end"}, 32'(task_o), 32'h0);
    endtask

    task automatic t_reset_r1();
        logic [31:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 first cycle quiet", 32'(task_o), 32'h0);
        rd(12'h510, d); chk("R1 ch0 event reset", d, 32'h0);
        rd(12'h514, d); chk("R1 ch0 task reset", d, 32'h0);
        rd(12'h98C, d); chk("R1 ch31 fork reset", d, 32'h0);
        fire("R1 zeroed channels silent", 8'hFF, 32'h000F_FFFF);
    endtask

    task automatic t_basic_r2();
        wr(12'h510, ea(2)); m_eep[0]  = ea(2);
        wr(12'h514, ta(1)); m_tep[0]  = ta(1);
        wr(12'h910, ta(5)); m_fork[0] = ta(5);
        fire("R2 primary plus fork", 8'h04, 32'h1);
        chk("R2 expected vector", 32'(exp_task(8'h04, 32'h1)), 32'h22);
        fire("R2 other event ignored", 8'h08, 32'h1);
    endtask

    task automatic t_readback_r3();
        logic [31:0] d;
        wr(12'h5A8, 32'hDEAD_BEEF); m_eep[19] = 32'hDEAD_BEEF;
        rd(12'h510, d); chk("R3 ch0 event readback", d, ea(2));
        rd(12'h514, d); chk("R3 ch0 task readback", d, ta(1));
        rd(12'h910, d); chk("R3 ch0 fork readback", d, ta(5));
        rd(12'h5A8, d); chk("R3 ch19 event full width", d, 32'hDEAD_BEEF);
        @(negedge clk); @(negedge clk);
        chk("R3 read data held", rd_data, 32'hDEAD_BEEF);
    endtask

    task automatic t_fixed_r4();
        logic [31:0] d;
        for (int k = 0; k < 12; k++) begin
            rd(12'h5B0 + 12'(8 * k), d); chk("R4 fixed event slot", d, ea(fx_e[k]));
            rd(12'h5B4 + 12'(8 * k), d); chk("R4 fixed task slot", d, ta(fx_t[k]));
        end
        wr(12'h5B0, ea(1));
        wr(12'h5B4, ta(7));
        rd(12'h5B0, d); chk("R4 write to fixed event ignored", d, ea(0));
        rd(12'h5B4, d); chk("R4 write to fixed task ignored", d, ta(0));
        fire("R4 fixed ch20 keeps event 0", 8'h02, 32'h0010_0000);
        fire("R4 fixed ch20 fires task 0", 8'h01, 32'h0010_0000);
    endtask

    task automatic t_fork_fixed_r5();
        logic [31:0] d;
        wr(12'h960, ta(4)); m_fork[20] = ta(4);
        rd(12'h960, d); chk("R5 fixed fork readback", d, ta(4));
        fire("R5 fixed fork with primary", 8'h01, 32'h0010_0000);
        chk("R5 expected vector", 32'(exp_task(8'h01, 32'h0010_0000)), 32'h11);
    endtask

    task automatic t_invalid_r6();
        wr(12'h518, ta(2));         m_eep[1] = ta(2);
        wr(12'h51C, ta(3));         m_tep[1] = ta(3);
        fire("R6 task address in event slot", 8'hFF, 32'h2);
        wr(12'h520, ea(1));         m_eep[2]  = ea(1);
        wr(12'h524, 32'h0);         m_tep[2]  = 32'h0;
        wr(12'h918, 32'h0000_0999); m_fork[2] = 32'h0000_0999;
        fire("R6 zero and misaligned tasks", 8'h02, 32'h4);
        wr(12'h524, ea(3));         m_tep[2] = ea(3);
        fire("R6 event address in task slot", 8'h02, 32'h4);
    endtask

    task automatic t_enable_r7();
        fire("R7 disabled channel 0", 8'h04, 32'hFFFF_FFFE);
        fire("R7 all disabled", 8'hFF, 32'h0);
    endtask

    task automatic t_fan_r8();
        wr(12'h528, ea(2)); m_eep[3] = ea(2);
        wr(12'h52C, ta(6)); m_tep[3] = ta(6);
        wr(12'h530, ea(7)); m_eep[4] = ea(7);
        wr(12'h534, ta(1)); m_tep[4] = ta(1);
        fire("R8 one event two channels", 8'h04, 32'h9);
        fire("R8 two channels one task", 8'h84, 32'h19);
        fire("R8 fixed and programmed OR", 8'h45, 32'hF010_0019);
    endtask

    initial begin
        for (int c = 0; c < 32; c++) begin
            m_eep[c]  = (c >= 20) ? ea(fx_e[c-20]) : 32'h0;
            m_tep[c]  = (c >= 20) ? ta(fx_t[c-20]) : 32'h0;
            m_fork[c] = 32'h0;
        end
        t_reset_r1();
        t_basic_r2();
        t_readback_r3();
        t_fixed_r4();
        t_fork_fixed_r5();
        t_invalid_r6();
        t_enable_r7();
        t_fan_r8();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule